// File: doc/BRIEF.md
# Privilege Ring Trap Decider

This block sits beside the instruction issue stage and judges each decoded instruction against the ring the core is running in. It then takes one of three actions. It lets the instruction run. It raises a trap so that the monitor regains control. Or it lets the instruction run with a reduced effect. The block holds the current 2-bit ring, where 0 is the most privileged and 3 the least. It also holds the flags word, which contains an interrupt-enable bit.

By convention the monitor runs in ring 0, a guest kernel in ring 1 and user programs in ring 3. Any generic privileged operation traps outside ring 0, and so does an access to the page-table base pointer. The flag-restore instruction is the exception: it never traps. In ring 0 it loads the whole popped flags value. In any other ring it loads every bit except interrupt-enable, which silently keeps its value. The exception path can also move the ring directly, and it can return from a trap to the ring that was saved when the trap was taken.

Top module: `priv_trap_unit`

## Requirements
- R1: While reset is asserted and after it is released, the ring is 0, all flag bits are 0 (interrupt-enable cleared), the trap request is low and the cause is 0.
- R2: In ring 0 every instruction class executes without a trap: ordinary (code 0), privileged (1), page-table-pointer read (2), page-table-pointer write (3) and flag-restore (4).
- R3: A valid privileged instruction (class 1) in ring 1, 2 or 3 raises the trap request with cause 1.
- R4: A valid page-table-pointer read (class 2) or write (class 3) in ring 1, 2 or 3 raises the trap request with cause 2.
- R5: The trap request is a one-cycle pulse. The ring reads 0 in the same cycle the pulse is high. The cause is 0 whenever the trap request is low.
- R6: A valid flag-restore (class 4) in ring 0 loads all flag bits from the popped value.
- R7: A valid flag-restore in ring 1, 2 or 3 loads every flag bit except interrupt-enable (bit IE_BIT, default 1), which keeps its old value, and it raises no trap.
- R8: A trap return moves the ring back to the ring that was saved when the last trap was taken.
- R9: A ring-set request loads the requested ring. In the same cycle, a trap outranks a trap return, and a trap return outranks a ring-set.
- R10: An ordinary instruction, or any input with the valid bit low, changes neither the flags nor the ring and raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A decoded instruction is present this cycle |
| instr_class | input | 3 | Instruction class code (0 to 4) |
| pop_flags | input | FLAG_W | Flags value popped from the stack |
| ring_set_en | input | 1 | Exception path asks for a direct ring load |
| ring_set_val | input | 2 | Ring to load |
| trap_ret | input | 1 | Return from trap: restore the saved ring |
| trap_req | output | 1 | Trap to the monitor (one-cycle pulse) |
| trap_cause | output | 2 | 0 none, 1 privileged instruction, 2 page-table-pointer access |
| flags_q | output | FLAG_W | Current flags |
| ring_q | output | 2 | Current ring |

## Verification
Every result is registered. Inputs applied in one cycle show up on trap_req, trap_cause, ring_q and flags_q right after the next rising edge, exactly one cycle later. The bench therefore drives each stimulus at a falling edge and checks all four outputs at the following falling edge. It does not check in between, so the one-cycle life of the trap pulse is checked by the vector that follows the trap. Return and ring-set results are read the same way, one cycle after the request.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
   localparam int RING_W = 2;
   localparam logic [RING_W-1:0] RING_TOP = '0;

   typedef enum logic [2:0] {
      IC_ALU          = 3'd0,
      IC_PRIV         = 3'd1,
      IC_PTB_RD       = 3'd2,
      IC_PTB_WR       = 3'd3,
      IC_FLAG_RESTORE = 3'd4
   } instr_class_e;

   typedef enum logic [1:0] {
      TC_NONE = 2'd0,
      TC_PRIV = 2'd1,
      TC_PTB  = 2'd2
   } trap_cause_e;
endpackage

// File: rtl/ptu_classify.sv
module ptu_classify
   import priv_trap_pkg::*;
(
   input  logic              valid,
   input  logic [2:0]        cls,
   input  logic [RING_W-1:0] ring,
   output logic              top_ring,
   output logic              take_trap,
   output logic [1:0]        cause,
   output logic              restore_en
);
   always_comb begin
      top_ring   = (ring == RING_TOP);
      take_trap  = 1'b0;
      cause      = TC_NONE;
      restore_en = 1'b0;
      if (valid) begin
         case (cls)
            IC_PRIV: begin
               if (!top_ring) begin
                  take_trap = 1'b1;
                  cause     = TC_PRIV;
               end
            end
            IC_PTB_RD, IC_PTB_WR: begin
               if (!top_ring) begin
                  take_trap = 1'b1;
                  cause     = TC_PTB;
               end
            end
            IC_FLAG_RESTORE: restore_en = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ptu_flag_merge.sv
module ptu_flag_merge #(
   parameter int FLAG_W = 8,
   parameter int IE_BIT = 1
) (
   input  logic [FLAG_W-1:0] cur_flags,
   input  logic [FLAG_W-1:0] pop_flags,
   input  logic              top_ring,
   output logic [FLAG_W-1:0] next_flags
);
   if (IE_BIT >= FLAG_W) begin : g_bad_ie
      $error("IE_BIT must lie inside the flags word");
   end

   for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
      if (i == IE_BIT) begin : g_ie
         assign next_flags[i] = top_ring ? pop_flags[i] : cur_flags[i];
      end else begin : g_plain
         assign next_flags[i] = pop_flags[i];
      end
   end
endmodule

// File: rtl/ptu_ring_ctl.sv
module ptu_ring_ctl
   import priv_trap_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_trap,
   input  logic              ret,
   input  logic              set_en,
   input  logic [RING_W-1:0] set_val,
   output logic [RING_W-1:0] ring_q,
   output logic [RING_W-1:0] saved_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ring_q  <= RING_TOP;
         saved_q <= RING_TOP;
      end else if (take_trap) begin
         saved_q <= ring_q;
         ring_q  <= RING_TOP;
      end else if (ret) begin
         ring_q  <= saved_q;
      end else if (set_en) begin
         ring_q  <= set_val;
      end
   end
endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
   import priv_trap_pkg::*;
#(
   parameter int FLAG_W = 8,
   parameter int IE_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [2:0]        instr_class,
   input  logic [FLAG_W-1:0] pop_flags,
   input  logic              ring_set_en,
   input  logic [1:0]        ring_set_val,
   input  logic              trap_ret,
   output logic              trap_req,
   output logic [1:0]        trap_cause,
   output logic [FLAG_W-1:0] flags_q,
   output logic [1:0]        ring_q
);
   if (FLAG_W < 2) begin : g_bad_w
      $error("FLAG_W must be at least 2");
   end

   logic              top_ring, take_trap, restore_en;
   logic [1:0]        cause_c;
   logic [FLAG_W-1:0] next_flags;
   logic [RING_W-1:0] saved_ring;

   ptu_classify u_cls (
      .valid      (instr_valid),
      .cls        (instr_class),
      .ring       (ring_q),
      .top_ring   (top_ring),
      .take_trap  (take_trap),
      .cause      (cause_c),
      .restore_en (restore_en)
   );

   ptu_flag_merge #(.FLAG_W(FLAG_W), .IE_BIT(IE_BIT)) u_merge (
      .cur_flags  (flags_q),
      .pop_flags  (pop_flags),
      .top_ring   (top_ring),
      .next_flags (next_flags)
   );

   ptu_ring_ctl u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_trap (take_trap),
      .ret       (trap_ret),
      .set_en    (ring_set_en),
      .set_val   (ring_set_val),
      .ring_q    (ring_q),
      .saved_q   (saved_ring)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_req   <= 1'b0;
         trap_cause <= TC_NONE;
         flags_q    <= '0;
      end else begin
         trap_req   <= take_trap;
         trap_cause <= cause_c;
         if (restore_en) flags_q <= next_flags;
      end
   end
endmodule

// File: rtl/priv_trap_chk.sv
module priv_trap_chk #(
   parameter int FLAG_W = 8,
   parameter int IE_BIT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic [2:0]        instr_class,
   input logic [FLAG_W-1:0] pop_flags,
   input logic              trap_req,
   input logic [1:0]        trap_cause,
   input logic [FLAG_W-1:0] flags_q,
   input logic [1:0]        ring_q,
   input logic [1:0]        saved_ring
);
   AST_TOP_RING_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && ring_q == 2'd0) |=> !trap_req);                         // R2
   AST_PRIV_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr_class == 3'd1 && ring_q != 2'd0)
      |=> (trap_req && trap_cause == 2'd1));                                  // R3
   AST_PTB_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && (instr_class == 3'd2 || instr_class == 3'd3) && ring_q != 2'd0)
      |=> (trap_req && trap_cause == 2'd2));                                  // R4
   AST_TRAP_IN_RING0: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (ring_q == 2'd0 && saved_ring == $past(ring_q)));         // R5
   AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_req |-> trap_cause == 2'd0);                                      // R5
   AST_RESTORE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr_class == 3'd4 && ring_q == 2'd0)
      |=> flags_q == $past(pop_flags));                                       // R6
   AST_IE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && instr_class == 3'd4 && ring_q != 2'd0)
      |=> (!trap_req && flags_q[IE_BIT] == $past(flags_q[IE_BIT])));         // R7
   AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(instr_valid && instr_class == 3'd4) |=> $stable(flags_q));            // R10
endmodule

bind priv_trap_unit priv_trap_chk #(.FLAG_W(FLAG_W), .IE_BIT(IE_BIT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr_class (instr_class),
   .pop_flags   (pop_flags),
   .trap_req    (trap_req),
   .trap_cause  (trap_cause),
   .flags_q     (flags_q),
   .ring_q      (ring_q),
   .saved_ring  (saved_ring)
);

// File: tb/tb_priv_trap_unit.sv
`timescale 1ns/1ps
module tb_priv_trap_unit;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       instr_valid;
   logic [2:0] instr_class;
   logic [7:0] pop_flags;
   logic       ring_set_en;
   logic [1:0] ring_set_val;
   logic       trap_ret;
   logic       trap_req;
   logic [1:0] trap_cause;
   logic [7:0] flags_q;
   logic [1:0] ring_q;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   priv_trap_unit dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_class(instr_class),
      .pop_flags(pop_flags), .ring_set_en(ring_set_en), .ring_set_val(ring_set_val),
      .trap_ret(trap_ret), .trap_req(trap_req), .trap_cause(trap_cause),
      .flags_q(flags_q), .ring_q(ring_q)
   );

   // {set_en, set_val, ret, valid, class, pop, exp_trap, exp_cause, exp_ring, exp_flags}
   localparam int NV = 21;
   localparam logic [28:0] VEC [NV] = '{
      {1'b0,2'd0,1'b0,1'b1,3'd4,8'hFF, 1'b0,2'd0,2'd0,8'hFF},
      {1'b0,2'd0,1'b0,1'b1,3'd1,8'h00, 1'b0,2'd0,2'd0,8'hFF},
      {1'b0,2'd0,1'b0,1'b1,3'd3,8'h00, 1'b0,2'd0,2'd0,8'hFF},
      {1'b1,2'd3,1'b0,1'b0,3'd0,8'h00, 1'b0,2'd0,2'd3,8'hFF},
      {1'b0,2'd0,1'b0,1'b1,3'd4,8'h00, 1'b0,2'd0,2'd3,8'h02},
      {1'b0,2'd0,1'b0,1'b1,3'd1,8'h00, 1'b1,2'd1,2'd0,8'h02},
      {1'b0,2'd0,1'b0,1'b0,3'd0,8'h00, 1'b0,2'd0,2'd0,8'h02},
      {1'b0,2'd0,1'b1,1'b0,3'd0,8'h00, 1'b0,2'd0,2'd3,8'h02},
      {1'b0,2'd0,1'b0,1'b1,3'd2,8'h00, 1'b1,2'd2,2'd0,8'h02},
      {1'b0,2'd0,1'b1,1'b0,3'd0,8'h00, 1'b0,2'd0,2'd3,8'h02},
      {1'b0,2'd0,1'b0,1'b0,3'd1,8'hAA, 1'b0,2'd0,2'd3,8'h02},
      {1'b1,2'd1,1'b0,1'b0,3'd0,8'h00, 1'b0,2'd0,2'd1,8'h02},
      {1'b0,2'd0,1'b0,1'b1,3'd4,8'hFD, 1'b0,2'd0,2'd1,8'hFF},
      {1'b0,2'd0,1'b0,1'b1,3'd3,8'h00, 1'b1,2'd2,2'd0,8'hFF},
      {1'b0,2'd0,1'b0,1'b1,3'd4,8'h00, 1'b0,2'd0,2'd0,8'h00},
      {1'b0,2'd0,1'b1,1'b0,3'd0,8'h00, 1'b0,2'd0,2'd1,8'h00},
      {1'b1,2'd2,1'b0,1'b1,3'd0,8'h33, 1'b0,2'd0,2'd2,8'h00},
      {1'b0,2'd0,1'b0,1'b1,3'd4,8'h5A, 1'b0,2'd0,2'd2,8'h58},
      {1'b1,2'd3,1'b1,1'b1,3'd1,8'h00, 1'b1,2'd1,2'd0,8'h58},
      {1'b1,2'd3,1'b1,1'b0,3'd0,8'h00, 1'b0,2'd0,2'd2,8'h58},
      {1'b0,2'd0,1'b0,1'b1,3'd0,8'hFF, 1'b0,2'd0,2'd2,8'h58}
   };

   function automatic string vec_req(int i);
      case (i)
         0, 14:          return "R6";
         1, 2:           return "R2";
         3, 11, 16:      return "R9";
         4, 12, 17:      return "R7";
         5:              return "R3";
         6:              return "R5";
         7, 9, 15:       return "R8";
         8, 13:          return "R4";
         18, 19:         return "R9";
         default:        return "R10";
      endcase
   endfunction

   task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      instr_valid = 1'b0; instr_class = 3'd0; pop_flags = 8'h00;
      ring_set_en = 1'b0; ring_set_val = 2'd0; trap_ret = 1'b0;
   endtask

   task automatic check_reset_state(string req);
      check(req, "trap_req", {7'd0, trap_req}, 8'h00);
      check(req, "trap_cause", {6'd0, trap_cause}, 8'h00);
      check(req, "ring", {6'd0, ring_q}, 8'h00);
      check(req, "flags", flags_q, 8'h00);
   endtask

   initial begin
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_reset_state("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state("R1");

      for (int i = 0; i < NV; i++) begin
         logic [28:0] v;
         v = VEC[i];
         ring_set_en  = v[28];
         ring_set_val = v[27:26];
         trap_ret     = v[25];
         instr_valid  = v[24];
         instr_class  = v[23:21];
         pop_flags    = v[20:13];
         @(negedge clk);
         check(vec_req(i), "trap_req", {7'd0, trap_req}, {7'd0, v[12]});
         check(vec_req(i), "trap_cause", {6'd0, trap_cause}, {6'd0, v[11:10]});
         check(vec_req(i), "ring", {6'd0, ring_q}, {6'd0, v[9:8]});
         check(vec_req(i), "flags", flags_q, v[7:0]);
      end

      // R1: reset from a user ring with flags set returns to the initial state
      idle_inputs();
      ring_set_en = 1'b1; ring_set_val = 2'd3;
      @(negedge clk);
      idle_inputs();
      instr_valid = 1'b1; instr_class = 3'd4; pop_flags = 8'hF0;
      @(negedge clk);
      check("R7", "flags before reset", flags_q, 8'hF0);
      idle_inputs();
      rst_n = 1'b0;
      @(negedge clk);
      check_reset_state("R1");
      rst_n = 1'b1;

      // R8: return with no earlier trap uses the reset value of the saved ring
      ring_set_en = 1'b1; ring_set_val = 2'd2;
      @(negedge clk);
      idle_inputs();
      trap_ret = 1'b1;
      @(negedge clk);
      check("R8", "ring after return", {6'd0, ring_q}, 8'h00);
      idle_inputs();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule